// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small 8-bit load/store processor that runs each instruction over several clock cycles. A 4-bit state register walks every instruction through four byte-wide fetch cycles and a decode cycle. It then takes an execution path chosen by the 6-bit opcode of the instruction held in the instruction register. The block is a Moore machine: every datapath strobe depends only on the present state. Those strobes are the per-byte instruction-register loads, the PC write and conditional PC write, the memory read and write, the memory address source, the register-file write with its destination and write-back selects, the two ALU operand selects, the ALU operation class and the PC source.

Six instruction kinds are handled: load byte, store byte, add-immediate, jump, register-register arithmetic and branch-if-equal. The register-register arithmetic group covers add, subtract, and, or and set-less-than, which the ALU decoder tells apart by the function field. Each next-state bit is formed as a sum of products of state-code matches and opcode matches. The machine raises a separate flag in the states where the ALU does the instruction's main computation, so that a clock generator outside the block can give those cycles a longer period.

Top module: `ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 0000. In that state `ir_wr_o`=0001, `mem_rd_o`=1, `pc_wr_o`=1, `src_b_o`=01, `alu_op_o`=00 and `pc_src_o`=00.
- R2: States 0000, 0001, 0010 and 0011 are fetch states and each moves to the next code. In fetch state k, `ir_wr_o` has only bit k set, and `mem_rd_o`, `pc_wr_o`=1 with `src_a_o`=0, `src_b_o`=01 (constant one), `alu_op_o`=00 (add) and `pc_src_o`=00.
- R3: From decode state 0100, the next state depends on the opcode. Opcodes 100000 (load byte), 101000 (store byte) and 001000 (add-immediate) lead to 0101. Opcode 000000 (register-register) leads to 1001, 000100 (branch-equal) to 1011, and 000010 (jump) to 1100.
- R4: Any other opcode in state 0100 returns the machine to 0000.
- R5: From address state 0101, load byte goes to 0110, store byte to 1000 and add-immediate to 1101. Any other opcode there goes to 0000.
- R6: State 0110 goes to 0111 and state 1001 goes to 1010. States 0111, 1000, 1010, 1011, 1100 and 1101 all go to 0000, as do the unused codes 1110 and 1111, which drive every output low.
- R7: `alu_exec_o` is high exactly in states 0101, 1001 and 1011.
- R8: In state 1011, `pc_wr_cond_o`=1, `pc_wr_o`=0, `src_a_o`=1, `src_b_o`=00, `alu_op_o`=01 (subtract) and `pc_src_o`=01. `pc_wr_cond_o` is low in every other state.
- R9: State 0110 drives `mem_rd_o`=1 with `addr_sel_o`=1, and state 1000 drives `mem_wr_o`=1 with `addr_sel_o`=1. `mem_wr_o` is high in no other state, and `mem_rd_o` and `mem_wr_o` are never high together.
- R10: `reg_wr_o` is high only in states 0111 (`wb_sel_o`=1, `reg_dst_o`=0), 1010 (`reg_dst_o`=1, `wb_sel_o`=0) and 1101 (`wb_sel_o`=0, `reg_dst_o`=0).
- R11: State 1100 drives `pc_wr_o`=1 with `pc_src_o`=10 and no other strobe.
- R12: Decode drives `src_a_o`=0, `src_b_o`=11 and `alu_op_o`=00. State 0101 drives `src_a_o`=1, `src_b_o`=10 and `alu_op_o`=00. State 1001 drives `src_a_o`=1, `src_b_o`=00 and `alu_op_o`=10 (function-field decode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 6 | Opcode field of the held instruction |
| state_o | output | 4 | Present state code |
| ir_wr_o | output | 4 | Per-byte instruction register load |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write qualified by ALU zero flag |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_sel_o | output | 1 | Memory address from ALU result (1) or PC (0) |
| reg_wr_o | output | 1 | Register file write |
| reg_dst_o | output | 1 | Destination from rd field (1) or rt field (0) |
| wb_sel_o | output | 1 | Write-back data from memory (1) or ALU result (0) |
| src_a_o | output | 1 | ALU A operand: register (1) or PC (0) |
| src_b_o | output | 2 | ALU B operand: 00 register, 01 constant one, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src_o | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_exec_o | output | 1 | Long-period ALU execution state flag |

## Verification
In two places, two separate functions of the unit fall in one cycle. In every fetch cycle the PC increment and the instruction-register byte load share the cycle. In the branch state the long-cycle ALU flag and the conditional PC write coincide. The random opcode stream passes through fetch and branch-equal paths thousands of times. Each cycle the bench compares the whole strobe vector and the flag against a reference model, so a missing or extra strobe in either cycle is reported. Reset is also dropped at random points, so that entry into a fetch state from the middle of a path is judged too.

// File: rtl/ctrl_pkg.sv
// Shared definitions for the multicycle control sequencer.
// Assumes a 6-bit opcode and a 4-byte instruction fetched one byte per cycle.
package ctrl_pkg;
    localparam int ST_W     = 4;
    localparam int OP_W     = 6;
    localparam int IR_BYTES = 4;
    localparam int ST_N     = 1 << ST_W;

    typedef enum logic [ST_W-1:0] {
        S_FET0  = 4'd0,
        S_FET1  = 4'd1,
        S_FET2  = 4'd2,
        S_FET3  = 4'd3,
        S_DEC   = 4'd4,
        S_ADDR  = 4'd5,
        S_LDRD  = 4'd6,
        S_LDWB  = 4'd7,
        S_STWR  = 4'd8,
        S_RGEX  = 4'd9,
        S_RGWB  = 4'd10,
        S_BREX  = 4'd11,
        S_JMP   = 4'd12,
        S_AIWB  = 4'd13
    } state_e;

    localparam logic [OP_W-1:0] OP_LDB  = 6'b100000;
    localparam logic [OP_W-1:0] OP_STB  = 6'b101000;
    localparam logic [OP_W-1:0] OP_ADDI = 6'b001000;
    localparam logic [OP_W-1:0] OP_JMP  = 6'b000010;
    localparam logic [OP_W-1:0] OP_RRR  = 6'b000000;
    localparam logic [OP_W-1:0] OP_BEQ  = 6'b000100;

    typedef struct packed {
        logic [IR_BYTES-1:0] ir_wr;
        logic                pc_wr;
        logic                pc_wr_cond;
        logic                mem_rd;
        logic                mem_wr;
        logic                addr_sel;
        logic                reg_wr;
        logic                reg_dst;
        logic                wb_sel;
        logic                src_a;
        logic [1:0]          src_b;
        logic [1:0]          alu_op;
        logic [1:0]          pc_src;
        logic                alu_exec;
    } ctrl_t;
endpackage

// File: rtl/ctrl_next.sv
// Next-state logic: each bit of the next code is a sum of products of
// one-hot state matches and opcode matches. Purely combinational.
// Assumes the state encoding of ctrl_pkg; unlisted paths fall to 0000.
module ctrl_next
    import ctrl_pkg::*;
(
    input  logic [ST_W-1:0] state_i,
    input  logic [OP_W-1:0] op_i,
    output logic [ST_W-1:0] next_o
);
    logic [ST_N-1:0] st;
    logic is_ldb, is_stb, is_addi, is_jmp, is_rrr, is_beq;

    // Decode the present state code into one match line per code.
    for (genvar k = 0; k < ST_N; k++) begin : g_match
        assign st[k] = (state_i == ST_W'(k));
    end

    // Opcode match lines.
    always_comb begin
        is_ldb  = (op_i == OP_LDB);
        is_stb  = (op_i == OP_STB);
        is_addi = (op_i == OP_ADDI);
        is_jmp  = (op_i == OP_JMP);
        is_rrr  = (op_i == OP_RRR);
        is_beq  = (op_i == OP_BEQ);
    end

    // Sum-of-products equation for each next-state bit.
    always_comb begin
        next_o[0] = st[0] | st[2] | st[6]
                  | (st[4] & (is_ldb | is_stb | is_addi | is_rrr | is_beq))
                  | (st[5] & is_addi);
        next_o[1] = st[1] | st[2] | st[6] | st[9]
                  | (st[5] & is_ldb)
                  | (st[4] & is_beq);
        next_o[2] = st[3] | st[6]
                  | (st[4] & (is_ldb | is_stb | is_addi | is_jmp))
                  | (st[5] & (is_ldb | is_addi));
        next_o[3] = st[9]
                  | (st[5] & (is_stb | is_addi))
                  | (st[4] & (is_rrr | is_beq | is_jmp));
    end
endmodule

// File: rtl/ctrl_decode.sv
// Moore output decoder: maps the present state onto the datapath strobes.
// Assumes the state encoding of ctrl_pkg; unused codes drive all strobes low.
module ctrl_decode
    import ctrl_pkg::*;
(
    input  logic [ST_W-1:0] state_i,
    output ctrl_t           ctrl_o
);
    // One case arm per state; defaults keep every strobe low.
    always_comb begin
        ctrl_o = '0;
        case (state_i)
            S_FET0, S_FET1, S_FET2, S_FET3: begin
                ctrl_o.ir_wr  = IR_BYTES'(1) << state_i[1:0];
                ctrl_o.mem_rd = 1'b1;
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.src_b  = 2'b01;
            end
            S_DEC: begin
                ctrl_o.src_b = 2'b11;
            end
            S_ADDR: begin
                ctrl_o.src_a    = 1'b1;
                ctrl_o.src_b    = 2'b10;
                ctrl_o.alu_exec = 1'b1;
            end
            S_LDRD: begin
                ctrl_o.mem_rd   = 1'b1;
                ctrl_o.addr_sel = 1'b1;
            end
            S_LDWB: begin
                ctrl_o.reg_wr = 1'b1;
                ctrl_o.wb_sel = 1'b1;
            end
            S_STWR: begin
                ctrl_o.mem_wr   = 1'b1;
                ctrl_o.addr_sel = 1'b1;
            end
            S_RGEX: begin
                ctrl_o.src_a    = 1'b1;
                ctrl_o.alu_op   = 2'b10;
                ctrl_o.alu_exec = 1'b1;
            end
            S_RGWB: begin
                ctrl_o.reg_wr  = 1'b1;
                ctrl_o.reg_dst = 1'b1;
            end
            S_BREX: begin
                ctrl_o.src_a      = 1'b1;
                ctrl_o.alu_op     = 2'b01;
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.pc_src     = 2'b01;
                ctrl_o.alu_exec   = 1'b1;
            end
            S_JMP: begin
                ctrl_o.pc_wr  = 1'b1;
                ctrl_o.pc_src = 2'b10;
            end
            S_AIWB: begin
                ctrl_o.reg_wr = 1'b1;
            end
            default: ctrl_o = '0;
        endcase
    end

    // Memory read and write strobes never overlap (R9).
    always_comb begin
        a_mem_excl_r9: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr));
    end
endmodule

// File: rtl/ctrl_fsm.sv
// Top of the multicycle control sequencer: holds the 4-bit state register
// and joins the next-state and output decoders.
// Assumes op_i is stable from the decode state until the path completes.
module ctrl_fsm
    import ctrl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [5:0]      op_i,
    output logic [3:0]      state_o,
    output logic [3:0]      ir_wr_o,
    output logic            pc_wr_o,
    output logic            pc_wr_cond_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            addr_sel_o,
    output logic            reg_wr_o,
    output logic            reg_dst_o,
    output logic            wb_sel_o,
    output logic            src_a_o,
    output logic [1:0]      src_b_o,
    output logic [1:0]      alu_op_o,
    output logic [1:0]      pc_src_o,
    output logic            alu_exec_o
);
    logic [ST_W-1:0] state_q;
    logic [ST_W-1:0] state_d;
    ctrl_t           ctrl;

    ctrl_next u_next (
        .state_i (state_q),
        .op_i    (op_i),
        .next_o  (state_d)
    );

    ctrl_decode u_dec (
        .state_i (state_q),
        .ctrl_o  (ctrl)
    );

    // State register with synchronous active-low reset to the first fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FET0;
        else        state_q <= state_d;
    end

    // Fan the control struct out onto the ports.
    always_comb begin
        state_o      = state_q;
        ir_wr_o      = ctrl.ir_wr;
        pc_wr_o      = ctrl.pc_wr;
        pc_wr_cond_o = ctrl.pc_wr_cond;
        mem_rd_o     = ctrl.mem_rd;
        mem_wr_o     = ctrl.mem_wr;
        addr_sel_o   = ctrl.addr_sel;
        reg_wr_o     = ctrl.reg_wr;
        reg_dst_o    = ctrl.reg_dst;
        wb_sel_o     = ctrl.wb_sel;
        src_a_o      = ctrl.src_a;
        src_b_o      = ctrl.src_b;
        alu_op_o     = ctrl.alu_op;
        pc_src_o     = ctrl.pc_src;
        alu_exec_o   = ctrl.alu_exec;
    end

    // First cycle out of reset sits in the first fetch state (R1).
    p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state_q == S_FET0);

    // Fetch states and the last fetch advance by one code (R2).
    p_fetch_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q <= S_FET3) |=> state_q == $past(state_q) + 4'd1);

    // An instruction byte load always comes with a PC increment (R2).
    p_irload_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_wr_o != '0) |-> ($onehot0(ir_wr_o) && pc_wr_o && mem_rd_o));

    // Unknown opcode in decode falls back to the first fetch (R4).
    p_undef_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEC && op_i != OP_LDB && op_i != OP_STB && op_i != OP_ADDI
         && op_i != OP_JMP && op_i != OP_RRR && op_i != OP_BEQ)
        |=> state_q == S_FET0);

    // The long ALU cycle never repeats back to back (R7).
    p_exec_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alu_exec_o |=> !alu_exec_o);

    // Conditional PC write happens only in an ALU cycle, never with a plain write (R8).
    p_branch_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond_o |-> (alu_exec_o && !pc_wr_o));

    // A register write ends the instruction (R10).
    p_wb_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> state_q == S_FET0);
endmodule

// File: tb/sim_ctrl_fsm.sv
// Self-checking bench: directed opcode paths, random opcode stream and random
// resets, compared every cycle against a reference model of the requirements.
module sim_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op = 6'd0;
    logic [3:0] state;
    logic [3:0] ir_wr;
    logic pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, reg_wr, reg_dst, wb_sel, src_a, alu_exec;
    logic [1:0] src_b, alu_op, pc_src;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] m_state = 4'd0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_fsm u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .state_o(state), .ir_wr_o(ir_wr),
        .pc_wr_o(pc_wr), .pc_wr_cond_o(pc_wr_cond), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .addr_sel_o(addr_sel), .reg_wr_o(reg_wr), .reg_dst_o(reg_dst), .wb_sel_o(wb_sel),
        .src_a_o(src_a), .src_b_o(src_b), .alu_op_o(alu_op), .pc_src_o(pc_src),
        .alu_exec_o(alu_exec)
    );

    // Reference next state from R3..R6.
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [5:0] o);
        case (s)
            4'd0, 4'd1, 4'd2, 4'd3: return s + 4'd1;
            4'd4: case (o)
                      6'b100000, 6'b101000, 6'b001000: return 4'd5;
                      6'b000000: return 4'd9;
                      6'b000100: return 4'd11;
                      6'b000010: return 4'd12;
                      default:   return 4'd0;
                  endcase
            4'd5: case (o)
                      6'b100000: return 4'd6;
                      6'b101000: return 4'd8;
                      6'b001000: return 4'd13;
                      default:   return 4'd0;
                  endcase
            4'd6: return 4'd7;
            4'd9: return 4'd10;
            default: return 4'd0;
        endcase
    endfunction

    // Reference strobes {ir_wr,pc_wr,pc_wr_cond,mem_rd,mem_wr,addr_sel,reg_wr,reg_dst,wb_sel,src_a,src_b,alu_op,pc_src}.
    function automatic logic [18:0] ref_out(input logic [3:0] s);
        logic [3:0] ir = 4'd0;
        logic pw = 0, pwc = 0, mr = 0, mw = 0, as = 0, rw = 0, rd = 0, ws = 0, sa = 0;
        logic [1:0] sb = 2'd0, ao = 2'd0, ps = 2'd0;
        if (s <= 4'd3) begin ir = 4'd1 << s; pw = 1; mr = 1; sb = 2'b01; end
        else if (s == 4'd4) sb = 2'b11;
        else if (s == 4'd5) begin sa = 1; sb = 2'b10; end
        else if (s == 4'd6) begin mr = 1; as = 1; end
        else if (s == 4'd7) begin rw = 1; ws = 1; end
        else if (s == 4'd8) begin mw = 1; as = 1; end
        else if (s == 4'd9) begin sa = 1; ao = 2'b10; end
        else if (s == 4'd10) begin rw = 1; rd = 1; end
        else if (s == 4'd11) begin sa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
        else if (s == 4'd12) begin pw = 1; ps = 2'b10; end
        else if (s == 4'd13) rw = 1;
        return {ir, pw, pwc, mr, mw, as, rw, rd, ws, sa, sb, ao, ps};
    endfunction

    function automatic string out_tag(input logic [3:0] s);
        case (s)
            4'd0, 4'd1, 4'd2, 4'd3: return "R2";
            4'd4, 4'd5, 4'd9:       return "R12";
            4'd6, 4'd8:             return "R9";
            4'd7, 4'd10, 4'd13:     return "R10";
            4'd11:                  return "R8";
            4'd12:                  return "R11";
            default:                return "R6";
        endcase
    endfunction

    function automatic string st_tag(input logic [3:0] prev, input logic [5:0] o, input bit was_rst);
        if (was_rst) return "R1";
        if (prev <= 4'd3) return "R2";
        if (prev == 4'd4) return (ref_next(prev, o) == 4'd0) ? "R4" : "R3";
        if (prev == 4'd5) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs with the model for the present model state.
    task automatic check_all(input string st_req);
        logic [18:0] act;
        act = {ir_wr, pc_wr, pc_wr_cond, mem_rd, mem_wr, addr_sel, reg_wr, reg_dst,
               wb_sel, src_a, src_b, alu_op, pc_src};
        check(st_req, "state", 32'(state), 32'(m_state));
        check(out_tag(m_state), "strobes", 32'(act), 32'(ref_out(m_state)));
        check("R7", "alu_exec", 32'(alu_exec),
              32'(m_state == 4'd5 || m_state == 4'd9 || m_state == 4'd11));
        if (mem_rd && mem_wr) check("R9", "rd_wr_overlap", 32'd1, 32'd0);
    endtask

    // One cycle: drive at negedge, advance model, check at the next negedge.
    task automatic step(input logic [5:0] o, input bit r);
        logic [3:0] prev;
        prev = m_state;
        op = o;
        rst_n = ~r;
        @(posedge clk);
        m_state = r ? 4'd0 : ref_next(prev, o);
        @(negedge clk);
        check_all(st_tag(prev, o, r));
    endtask

    task automatic run_path(input logic [5:0] o);
        for (int k = 0; k < 12; k++) begin
            step(o, 1'b0);
            if (m_state == 4'd0) break;
        end
    endtask

    function automatic logic [5:0] pick_op(input int unsigned r);
        case (r % 8)
            0: return 6'b100000;
            1: return 6'b101000;
            2: return 6'b001000;
            3: return 6'b000010;
            4: return 6'b000000;
            5: return 6'b000100;
            default: return 6'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(6'd0, 1'b1);
        step(6'd0, 1'b1);
        // R1: reset state with fetch-0 strobes
        check("R1", "reset_ir_wr", 32'(ir_wr), 32'h1);
        check("R1", "reset_state", 32'(state), 32'h0);
        // Directed: every opcode path, plus undefined codes (R4) and resets mid-path.
        run_path(6'b100000);
        run_path(6'b101000);
        run_path(6'b001000);
        run_path(6'b000010);
        run_path(6'b000000);
        run_path(6'b000100);
        run_path(6'b111111);
        run_path(6'b000001);
        for (int k = 0; k < 5; k++) step(6'b000100, 1'b0);
        step(6'b000100, 1'b1);
        // Random: opcode held per instruction, occasional reset.
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] o;
            o = pick_op($urandom);
            for (int k = 0; k < 12; k++) begin
                bit r;
                r = ($urandom % 97) == 0;
                step(o, r);
                if (m_state == 4'd0) break;
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule